// File: doc/BRIEF.md
# Write-Completion Acknowledge Polling Sequencer

A two-wire serial memory runs an internal write cycle after the stop that ends a write. That cycle takes about 5 ms and at most 10 ms. While it runs, the memory answers no address. This block is the master-side controller that waits out that interval by probing the memory. A host pulses a request. The request carries the 7-bit device address, a flag telling whether the next operation is a write, and a limit on the number of probes. The sequencer then drives a bit-level bus engine through a simple command/response interface. It sends one command pulse per step and then waits for the engine's done strobe. The done strobe comes with the acknowledge bit the engine sampled.

Each probe is a start condition followed by the address byte, with the read/write bit cleared. A NACK means the memory is still busy, so the sequencer issues a fresh start. No stop is sent between probes. An ACK ends polling in one of two ways. If a write comes next, the bus is left held and the host continues straight away. Otherwise a stop is sent first. If the probe limit runs out, the sequencer sends a stop and reports a timeout. Every run ends with a single-cycle ready pulse. Two status flags are valid only during that pulse.

Top module: `ack_poll_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `cmd_valid`, `ready`, `bus_held` and `timeout_err` are all 0, and `cmd_op` is 0.
- R2: `req` is accepted only while `busy` is 0. A `req` seen while busy does not change the command sequence or the outcome of the run in progress.
- R3: Each probe is a START command (`cmd_op`=1) followed by a BYTE command (`cmd_op`=2). The BYTE command carries `cmd_byte` = {address[6:0], 1'b0}, so bit 0 is the write direction, 0.
- R4: Every command is a `cmd_valid` pulse lasting exactly one cycle. Each command after the first is issued in the cycle after the cycle in which `eng_done` was sampled high, and no command is issued while an engine step is outstanding.
- R5: A NACK on the address byte (`eng_ack`=0 with `eng_done`) starts a new probe with START when the limit has not been reached. No STOP is sent between probes.
- R6: An ACK with next-write set ends the run without a STOP. The result is a ready pulse with `bus_held`=1 and `timeout_err`=0, one cycle after the acknowledged done.
- R7: An ACK with next-write clear issues STOP (`cmd_op`=3). After that STOP completes, the run ends with a ready pulse with `bus_held`=0 and `timeout_err`=0.
- R8: When the number of NACKed probes reaches the captured limit, the block issues STOP. It then gives a ready pulse with `timeout_err`=1 and `bus_held`=0. A limit of 0 behaves as 1. An ACK on the last allowed probe is a success.
- R9: `ready` lasts exactly one cycle, and `bus_held` and `timeout_err` are 0 whenever `ready` is 0.
- R10: The first START is issued in the cycle after `req` is sampled in idle, and `busy` stays 1 from then through the ready cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start a polling run (taken only when idle) |
| req_next_write | input | 1 | The operation after polling is a write |
| req_addr | input | 7 | Device address placed in the probe byte |
| req_max_polls | input | CNT_W | Maximum number of probes (0 treated as 1) |
| eng_done | input | 1 | Bus engine finished the current command |
| eng_ack | input | 1 | Acknowledge sampled by the engine, valid with eng_done |
| cmd_valid | output | 1 | One-cycle command strobe to the engine |
| cmd_op | output | 2 | 1 = START, 2 = BYTE, 3 = STOP, 0 = none |
| cmd_byte | output | 8 | Byte to shift out for BYTE commands |
| busy | output | 1 | A polling run is in progress |
| ready | output | 1 | One-cycle completion pulse |
| bus_held | output | 1 | With ready: bus left held, no stop sent |
| timeout_err | output | 1 | With ready: probe limit exhausted |

## Verification
Several properties are checked on every cycle. Command and ready strobes must be single-cycle. The direction bit of every probe byte must be 0. Status flags may appear only with ready. A held-bus result must follow an acknowledged done directly. Every command other than the first START must be caused by a done strobe. Other behaviour can only be shown by the bench's scenarios. These include the exact order and number of commands for a given count of busy probes, and the choice between STOP and held bus that follows from the next-write flag. They also include the boundary where an ACK lands on the final allowed probe against one probe too late, the zero limit, and the rejection of a request made mid-run.

// File: rtl/aps_pkg.sv
package aps_pkg;

    localparam int PROBE_AW = 7;
    localparam int BYTE_W   = 8;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_START = 2'd1,
        OP_BYTE  = 2'd2,
        OP_STOP  = 2'd3
    } bus_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_WSTART,
        ST_ADDR,
        ST_WADDR,
        ST_STOP,
        ST_WSTOP,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic [PROBE_AW-1:0] addr;
        logic                next_write;
    } probe_ctx_t;

    typedef struct packed {
        logic              valid;
        bus_op_e           op;
        logic [BYTE_W-1:0] data;
    } bus_cmd_t;

    // Probe byte: device address in the upper bits, direction bit 0 = write.
    function automatic logic [BYTE_W-1:0] probe_byte(input logic [PROBE_AW-1:0] a);
        return {a, 1'b0};
    endfunction

endpackage

// File: rtl/aps_ctx.sv
module aps_ctx
    import aps_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [PROBE_AW-1:0] addr_in,
    input  logic                next_write_in,
    input  logic [CNT_W-1:0]    max_polls_in,
    output probe_ctx_t          ctx,
    output logic [CNT_W-1:0]    limit
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx   <= '0;
            limit <= ONE;
        end else if (load) begin
            ctx.addr       <= addr_in;
            ctx.next_write <= next_write_in;
            limit          <= (max_polls_in == '0) ? ONE : max_polls_in;
        end
    end

endmodule

// File: rtl/aps_counter.sv
module aps_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic             limit_hit
);

    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [EXT_W-1:0] after_this;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // The probe now being answered is number cnt_q + 1.
    assign after_this = {1'b0, cnt_q} + EXT_W'(1);
    assign limit_hit  = (after_this >= {1'b0, limit});

endmodule

// File: rtl/aps_fsm.sv
module aps_fsm
    import aps_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       eng_done,
    input  logic       eng_ack,
    input  logic       next_write,
    input  logic       limit_hit,
    output seq_state_e state,
    output logic       accept,
    output logic       cnt_clear,
    output logic       cnt_inc,
    output logic       held_q,
    output logic       tmo_q
);

    seq_state_e state_d;
    logic       held_d;
    logic       tmo_d;

    always_comb begin
        state_d   = state;
        accept    = 1'b0;
        cnt_clear = 1'b0;
        cnt_inc   = 1'b0;
        held_d    = held_q;
        tmo_d     = tmo_q;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    accept    = 1'b1;
                    cnt_clear = 1'b1;
                    held_d    = 1'b0;
                    tmo_d     = 1'b0;
                    state_d   = ST_START;
                end
            end
            ST_START:  state_d = ST_WSTART;
            ST_WSTART: if (eng_done) state_d = ST_ADDR;
            ST_ADDR:   state_d = ST_WADDR;
            ST_WADDR: begin
                if (eng_done) begin
                    if (eng_ack) begin
                        if (next_write) begin
                            held_d  = 1'b1;
                            state_d = ST_FIN;
                        end else begin
                            state_d = ST_STOP;
                        end
                    end else if (limit_hit) begin
                        tmo_d   = 1'b1;
                        state_d = ST_STOP;
                    end else begin
                        cnt_inc = 1'b1;
                        state_d = ST_START;
                    end
                end
            end
            ST_STOP:   state_d = ST_WSTOP;
            ST_WSTOP:  if (eng_done) state_d = ST_FIN;
            ST_FIN:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            held_q <= 1'b0;
            tmo_q  <= 1'b0;
        end else begin
            state  <= state_d;
            held_q <= held_d;
            tmo_q  <= tmo_d;
        end
    end

endmodule

// File: rtl/aps_cmd.sv
module aps_cmd
    import aps_pkg::*;
(
    input  seq_state_e state,
    input  probe_ctx_t ctx,
    input  logic       held_q,
    input  logic       tmo_q,
    output bus_cmd_t   cmd,
    output logic       busy,
    output logic       ready,
    output logic       bus_held,
    output logic       timeout_err
);

    always_comb begin
        cmd = '{valid: 1'b0, op: OP_NONE, data: '0};
        unique case (state)
            ST_START: cmd = '{valid: 1'b1, op: OP_START, data: '0};
            ST_ADDR:  cmd = '{valid: 1'b1, op: OP_BYTE,  data: probe_byte(ctx.addr)};
            ST_STOP:  cmd = '{valid: 1'b1, op: OP_STOP,  data: '0};
            default:  cmd = '{valid: 1'b0, op: OP_NONE,  data: '0};
        endcase
    end

    assign busy        = (state != ST_IDLE);
    assign ready       = (state == ST_FIN);
    assign bus_held    = ready & held_q;
    assign timeout_err = ready & tmo_q;

endmodule

// File: rtl/ack_poll_seq.sv
module ack_poll_seq
    import aps_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req,
    input  logic                 req_next_write,
    input  logic [PROBE_AW-1:0]  req_addr,
    input  logic [CNT_W-1:0]     req_max_polls,
    input  logic                 eng_done,
    input  logic                 eng_ack,
    output logic                 cmd_valid,
    output logic [1:0]           cmd_op,
    output logic [BYTE_W-1:0]    cmd_byte,
    output logic                 busy,
    output logic                 ready,
    output logic                 bus_held,
    output logic                 timeout_err
);

    probe_ctx_t       ctx;
    logic [CNT_W-1:0] limit;
    logic             limit_hit;
    seq_state_e       state;
    logic             accept;
    logic             cnt_clear;
    logic             cnt_inc;
    logic             held_q;
    logic             tmo_q;
    bus_cmd_t         cmd;

    aps_ctx #(.CNT_W(CNT_W)) u_ctx (
        .clk           (clk),
        .rst           (rst),
        .load          (accept),
        .addr_in       (req_addr),
        .next_write_in (req_next_write),
        .max_polls_in  (req_max_polls),
        .ctx           (ctx),
        .limit         (limit)
    );

    aps_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .clear     (cnt_clear),
        .inc       (cnt_inc),
        .limit     (limit),
        .limit_hit (limit_hit)
    );

    aps_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .eng_done   (eng_done),
        .eng_ack    (eng_ack),
        .next_write (ctx.next_write),
        .limit_hit  (limit_hit),
        .state      (state),
        .accept     (accept),
        .cnt_clear  (cnt_clear),
        .cnt_inc    (cnt_inc),
        .held_q     (held_q),
        .tmo_q      (tmo_q)
    );

    aps_cmd u_out (
        .state       (state),
        .ctx         (ctx),
        .held_q      (held_q),
        .tmo_q       (tmo_q),
        .cmd         (cmd),
        .busy        (busy),
        .ready       (ready),
        .bus_held    (bus_held),
        .timeout_err (timeout_err)
    );

    assign cmd_valid = cmd.valid;
    assign cmd_op    = cmd.op;
    assign cmd_byte  = cmd.data;

endmodule

// File: rtl/aps_checker.sv
module aps_checker
    import aps_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       req,
    input logic       eng_done,
    input logic       eng_ack,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic [7:0] cmd_byte,
    input logic       busy,
    input logic       ready,
    input logic       bus_held,
    input logic       timeout_err
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!cmd_valid && !ready));

    p_cmd_while_busy_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> busy);

    p_probe_dir_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_BYTE) |-> (cmd_byte[0] == 1'b0));

    p_cmd_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    p_cmd_after_done_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op != OP_START) |-> $past(eng_done));

    p_start_cause_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_START) |-> ($past(req) || $past(eng_done)));

    p_held_after_ack_r6: assert property (@(posedge clk) disable iff (rst)
        (ready && bus_held) |-> $past(eng_done && eng_ack));

    p_tmo_not_held_r8: assert property (@(posedge clk) disable iff (rst)
        ready |-> !(bus_held && timeout_err));

    p_ready_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    p_flags_gated_r9: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (!bus_held && !timeout_err));

endmodule

bind ack_poll_seq aps_checker u_chk (.*);

// File: tb/ack_poll_seq_test.sv
`timescale 1ns/1ps
module ack_poll_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        req_next_write = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [15:0] req_max_polls = '0;
    logic        eng_done = 1'b0;
    logic        eng_ack = 1'b0;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [7:0]  cmd_byte;
    logic        busy;
    logic        ready;
    logic        bus_held;
    logic        timeout_err;

    ack_poll_seq #(.CNT_W(16)) uut (
        .clk(clk), .rst(rst), .req(req), .req_next_write(req_next_write),
        .req_addr(req_addr), .req_max_polls(req_max_polls),
        .eng_done(eng_done), .eng_ack(eng_ack),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
        .busy(busy), .ready(ready), .bus_held(bus_held), .timeout_err(timeout_err)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // Expected event queue: kind 1 START, 2 BYTE, 3 STOP, 4 READY
    int q_kind[$];
    int q_byte[$];
    int q_held[$];
    int q_tmo[$];
    int due = -1;
    int txn_start = 0;
    bit running = 1'b0;

    // Engine model state
    int lat = 1;
    int nack_left = 0;
    int eng_cnt = 0;
    bit pend_ack = 1'b0;

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", rq, what, act, exp, cyc);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Reference monitor and engine model, both at the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            int exp_busy;
            exp_busy = (running && cyc >= txn_start) ? 1 : 0;
            chk(busy == exp_busy, "R10", "busy", busy, exp_busy);
            if (cyc == due && q_kind.size() > 0) begin
                int k, b, h, t;
                k = q_kind.pop_front(); b = q_byte.pop_front();
                h = q_held.pop_front(); t = q_tmo.pop_front();
                if (k == 4) begin
                    chk(ready == 1'b1, "R9", "ready pulse", ready, 1);
                    chk(cmd_valid == 1'b0, "R4", "cmd during ready", cmd_valid, 0);
                    chk(bus_held == h, (h != 0) ? "R6" : "R7", "bus_held", bus_held, h);
                    chk(timeout_err == t, "R8", "timeout_err", timeout_err, t);
                    due = -1;
                    running = 1'b0;
                end else begin
                    chk(cmd_valid == 1'b1, "R4", "cmd_valid due", cmd_valid, 1);
                    chk(int'(cmd_op) == k, (k == 3) ? "R7" : "R5", "cmd_op", cmd_op, k);
                    chk(ready == 1'b0, "R9", "ready during cmd", ready, 0);
                    if (k == 2) chk(int'(cmd_byte) == b, "R3", "probe byte", cmd_byte, b);
                    due = cyc + lat + 1;
                end
            end else begin
                chk(cmd_valid == 1'b0, "R4", "spurious cmd_valid", cmd_valid, 0);
                chk(ready == 1'b0, "R9", "spurious ready", ready, 0);
                chk(bus_held == 1'b0 && timeout_err == 1'b0, "R9", "flags without ready",
                    {bus_held, timeout_err}, 0);
            end
        end
        // engine
        eng_done = 1'b0;
        eng_ack  = 1'b0;
        if (eng_cnt > 0) begin
            eng_cnt--;
            if (eng_cnt == 0) begin
                eng_done = 1'b1;
                eng_ack  = pend_ack;
            end
        end
        if (!rst && cmd_valid) begin
            eng_cnt = lat;
            pend_ack = 1'b0;
            if (cmd_op == 2'd2) begin
                if (nack_left > 0) nack_left--;
                else pend_ack = 1'b1;
            end
        end
    end

    task automatic push_ev(input int k, input int b, input int h, input int t);
        q_kind.push_back(k); q_byte.push_back(b); q_held.push_back(h); q_tmo.push_back(t);
    endtask

    task automatic run_txn(input logic [6:0] a, input bit nw, input int maxp,
                           input int nbusy, input int l, input bit poke);
        int neff, probes, w;
        bit acked;
        neff   = (maxp == 0) ? 1 : maxp;
        acked  = (nbusy < neff);
        probes = acked ? nbusy + 1 : neff;
        for (int p = 0; p < probes; p++) begin
            push_ev(1, 0, 0, 0);
            push_ev(2, {a, 1'b0}, 0, 0);
        end
        if (acked && nw) push_ev(4, 0, 1, 0);
        else begin
            push_ev(3, 0, 0, 0);
            push_ev(4, 0, 0, acked ? 0 : 1);
        end
        lat = l;
        nack_left = nbusy;
        @(negedge clk);
        req = 1'b1; req_addr = a; req_next_write = nw; req_max_polls = 16'(maxp);
        txn_start = cyc + 1;
        due = cyc + 1;
        running = 1'b1;
        @(negedge clk);
        req = 1'b0;
        if (poke) begin
            // R2: request while busy must be ignored
            repeat (2) @(negedge clk);
            req = 1'b1; req_addr = ~a; req_next_write = ~nw; req_max_polls = 16'd1;
            @(negedge clk);
            req = 1'b0;
        end
        w = 0;
        while (running && w < 3000) begin
            @(negedge clk);
            w++;
        end
        if (running) begin
            chk(1'b0, "R4", "watchdog run did not finish", 0, 1);
            running = 1'b0;
            due = -1;
            q_kind.delete(); q_byte.delete(); q_held.delete(); q_tmo.delete();
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b0, "R1", "reset busy", busy, 0);
        chk(cmd_valid == 1'b0 && cmd_op == 2'd0, "R1", "reset cmd", {cmd_valid, cmd_op}, 0);
        chk(ready == 1'b0 && bus_held == 1'b0 && timeout_err == 1'b0, "R1", "reset status",
            {ready, bus_held, timeout_err}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        run_txn(7'h50, 1'b1, 5, 0, 1, 1'b0);   // R6: immediate ACK, write follows
        run_txn(7'h2A, 1'b0, 10, 3, 2, 1'b0);  // R5 R7: three NACKs then ACK, stop
        run_txn(7'h7F, 1'b1, 3, 5, 1, 1'b0);   // R8: limit exhausted
        run_txn(7'h00, 1'b0, 0, 2, 1, 1'b0);   // R8: limit 0 acts as 1
        run_txn(7'h13, 1'b1, 3, 2, 3, 1'b0);   // R8: ACK on last allowed probe
        run_txn(7'h41, 1'b0, 8, 4, 2, 1'b1);   // R2: request during run ignored
        run_txn(7'h3C, 1'b1, 2, 2, 1, 1'b1);   // R2 R8: ignored request, timeout
        run_txn(7'h55, 1'b0, 1, 0, 4, 1'b0);   // R7: single probe ACK, stop

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        fails++;
        $display("FAIL R4 global watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule